// File: doc/BRIEF.md
# Virtual block permission checker

This block guards memory accesses that name a global block instead of a flat virtual address. It keeps a small table of blocks. Each block has a power-of-two size, an enable flag, an 8-bit property vector and a count of how many processes hold it. For every process it also keeps a short list of attached blocks, each with its own read, write and execute rights. Software builds this state one command at a time: create, enable, disable, attach, detach, free and query.

An access names a process, a block, an offset and an access kind. The block answers grant or fault, with a coded cause, one cycle after the access is accepted. No address translation is involved. Translation is left to later stages, so protection and translation stay separate. Many processes may attach to the same block with different rights, and the reference count tracks them.

Top module: `vblk_guard`

## Requirements
- R1: A create command succeeds only when the block is not in use and the size exponent `cmd_lg` lies in 12..47; otherwise it reports an error and changes nothing. A created block starts disabled, with a reference count of 0 and the given property vector.
- R2: Enable (op 1) and disable (op 2) set or clear the enable flag of an existing block. They, and any command other than create, report an error when aimed at a block that does not exist. Op 7 always reports an error.
- R3: Attach (op 3) records the block for the process with rights `cmd_perm` (bit0 read, bit1 write, bit2 execute) and adds one to the block's count. It is rejected without any state change if the block does not exist, if the process already holds it, or if the process already holds 8 blocks.
- R4: Detach (op 4) removes the process's attachment and subtracts one from the count. Detaching a block the process does not hold is rejected.
- R5: Free (op 5) is rejected while the block's count is nonzero. Once it succeeds, the block no longer exists.
- R6: Every command yields `cmd_rsp_valid` on the next cycle. For query (op 6) the response carries the block's size exponent, the property vector exactly as stored, the enable flag and the count. Create is op 0.
- R7: An access (`acc_type` 0 read, 1 write, 2 execute, 3 never permitted) is granted only when the block exists and is enabled, the process holds it, the held rights include the requested kind, and the offset is below 2^exponent.
- R8: A fault reports a cause chosen in this order: 1 block missing or disabled, 2 not attached, 3 right missing, 4 offset out of range. A grant reports cause 0.
- R9: An access is accepted when `acc_valid` and `acc_ready` are both high, and its result appears with `res_valid` in the next cycle only. `acc_ready` is low in any cycle that carries a command, so the command wins.
- R10: The property vector has no effect on grant or fault decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_blk | input | 4 | Target block |
| cmd_proc | input | 3 | Target process for attach/detach |
| cmd_perm | input | 3 | Rights for attach |
| cmd_lg | input | 6 | Size exponent for create |
| cmd_prop | input | 8 | Property vector for create |
| cmd_rsp_valid | output | 1 | Command response strobe |
| cmd_rsp_err | output | 1 | Command was rejected |
| rsp_en | output | 1 | Query: enable flag |
| rsp_lg | output | 6 | Query: size exponent |
| rsp_prop | output | 8 | Query: property vector |
| rsp_refcnt | output | 4 | Query: attached-process count |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Access may be accepted |
| acc_proc | input | 3 | Requesting process |
| acc_blk | input | 4 | Requested block |
| acc_off | input | 47 | Offset inside the block |
| acc_type | input | 2 | Access kind |
| res_valid | output | 1 | Access result strobe |
| res_grant | output | 1 | Access allowed |
| res_cause | output | 3 | Fault cause code |

## Verification
Both the command response and the access result come from a single register, so each is due exactly one cycle after the edge that accepts its stimulus. The bench drives inputs on a falling edge and reads the result on the next falling edge, half a cycle after that register loads. A command that overlaps an access is checked at the same point: `res_valid` must stay low there, because `acc_ready` was low beforehand. Between stimuli the bench keeps a model of blocks and attachments and compares every response against it.

// File: rtl/vbp_pkg.sv
package vbp_pkg;
    localparam int NBLK   = 16;
    localparam int NPROC  = 8;
    localparam int NSLOT  = 8;
    localparam int PROPW  = 8;
    localparam int OFFW   = 47;
    localparam int LOGW   = 6;
    localparam int MINLOG = 12;
    localparam int MAXLOG = 47;
    localparam int BIDW   = $clog2(NBLK);
    localparam int PIDW   = $clog2(NPROC);
    localparam int SIDW   = $clog2(NSLOT);
    localparam int REFW   = $clog2(NPROC + 1);

    typedef enum logic [2:0] {
        OP_CREATE  = 3'd0,
        OP_ENABLE  = 3'd1,
        OP_DISABLE = 3'd2,
        OP_ATTACH  = 3'd3,
        OP_DETACH  = 3'd4,
        OP_FREE    = 3'd5,
        OP_QUERY   = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        FC_NONE     = 3'd0,
        FC_DISABLED = 3'd1,
        FC_DETACHED = 3'd2,
        FC_RIGHTS   = 3'd3,
        FC_RANGE    = 3'd4
    } fault_e;

    typedef struct packed {
        logic             ex;
        logic             en;
        logic [LOGW-1:0]  lg;
        logic [PROPW-1:0] prop;
        logic [REFW-1:0]  refc;
    } blk_t;

    function automatic logic right_held(logic [2:0] rights, logic [1:0] kind);
        return (kind == 2'd3) ? 1'b0 : rights[kind];
    endfunction

    function automatic logic beyond_end(logic [OFFW-1:0] off, logic [LOGW-1:0] lg);
        return (off >> lg) != '0;
    endfunction
endpackage

// File: rtl/vbp_blk_table.sv
module vbp_blk_table
    import vbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BIDW-1:0]  wr_blk,
    input  logic             do_create,
    input  logic             do_enable,
    input  logic             do_disable,
    input  logic             do_inc,
    input  logic             do_dec,
    input  logic             do_free,
    input  logic [LOGW-1:0]  new_lg,
    input  logic [PROPW-1:0] new_prop,
    input  logic [BIDW-1:0]  ra_blk,
    input  logic [BIDW-1:0]  rb_blk,
    output blk_t             ra,
    output blk_t             rb
);
    blk_t tbl [NBLK];

    assign ra = tbl[ra_blk];
    assign rb = tbl[rb_blk];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBLK; i++) tbl[i] <= '0;
        end else if (do_create) begin
            tbl[wr_blk] <= '{ex: 1'b1, en: 1'b0, lg: new_lg, prop: new_prop, refc: '0};
        end else if (do_enable) begin
            tbl[wr_blk].en <= 1'b1;
        end else if (do_disable) begin
            tbl[wr_blk].en <= 1'b0;
        end else if (do_inc) begin
            tbl[wr_blk].refc <= tbl[wr_blk].refc + 1'b1;
        end else if (do_dec) begin
            tbl[wr_blk].refc <= tbl[wr_blk].refc - 1'b1;
        end else if (do_free) begin
            tbl[wr_blk] <= '0;
        end
    end
endmodule

// File: rtl/vbp_attach_list.sv
module vbp_attach_list
    import vbp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PIDW-1:0] c_proc,
    input  logic [BIDW-1:0] c_blk,
    input  logic [2:0]      c_rights,
    input  logic            do_attach,
    input  logic            do_detach,
    output logic            c_hit,
    output logic            c_full,
    input  logic [PIDW-1:0] a_proc,
    input  logic [BIDW-1:0] a_blk,
    output logic            a_hit,
    output logic [2:0]      a_rights
);
    logic            sv [NPROC][NSLOT];
    logic [BIDW-1:0] sb [NPROC][NSLOT];
    logic [2:0]      sr [NPROC][NSLOT];

    logic [SIDW-1:0] hit_idx, free_idx;

    always_comb begin
        c_hit    = 1'b0;
        c_full   = 1'b1;
        hit_idx  = '0;
        free_idx = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (sv[c_proc][s] && sb[c_proc][s] == c_blk) begin
                c_hit   = 1'b1;
                hit_idx = SIDW'(s);
            end
            if (!sv[c_proc][s]) begin
                c_full   = 1'b0;
                free_idx = SIDW'(s);
            end
        end
    end

    always_comb begin
        a_hit    = 1'b0;
        a_rights = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (sv[a_proc][s] && sb[a_proc][s] == a_blk) begin
                a_hit    = 1'b1;
                a_rights = sr[a_proc][s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPROC; p++) begin
                for (int s = 0; s < NSLOT; s++) begin
                    sv[p][s] <= 1'b0;
                    sb[p][s] <= '0;
                    sr[p][s] <= '0;
                end
            end
        end else if (do_attach) begin
            sv[c_proc][free_idx] <= 1'b1;
            sb[c_proc][free_idx] <= c_blk;
            sr[c_proc][free_idx] <= c_rights;
        end else if (do_detach) begin
            sv[c_proc][hit_idx] <= 1'b0;
        end
    end
endmodule

// File: rtl/vbp_lookup.sv
module vbp_lookup
    import vbp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fire,
    input  blk_t            info,
    input  logic            hit,
    input  logic [2:0]      rights,
    input  logic [1:0]      kind,
    input  logic [OFFW-1:0] off,
    output logic            res_valid,
    output logic            res_grant,
    output logic [2:0]      res_cause
);
    fault_e cause;

    always_comb begin
        if (!(info.ex && info.en))          cause = FC_DISABLED;
        else if (!hit)                      cause = FC_DETACHED;
        else if (!right_held(rights, kind)) cause = FC_RIGHTS;
        else if (beyond_end(off, info.lg))  cause = FC_RANGE;
        else                                cause = FC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_grant <= 1'b0;
            res_cause <= '0;
        end else begin
            res_valid <= fire;
            res_grant <= fire && (cause == FC_NONE);
            res_cause <= fire ? cause : FC_NONE;
        end
    end
endmodule

// File: rtl/vblk_guard.sv
module vblk_guard
    import vbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [BIDW-1:0]  cmd_blk,
    input  logic [PIDW-1:0]  cmd_proc,
    input  logic [2:0]       cmd_perm,
    input  logic [LOGW-1:0]  cmd_lg,
    input  logic [PROPW-1:0] cmd_prop,
    output logic             cmd_rsp_valid,
    output logic             cmd_rsp_err,
    output logic             rsp_en,
    output logic [LOGW-1:0]  rsp_lg,
    output logic [PROPW-1:0] rsp_prop,
    output logic [REFW-1:0]  rsp_refcnt,
    input  logic             acc_valid,
    output logic             acc_ready,
    input  logic [PIDW-1:0]  acc_proc,
    input  logic [BIDW-1:0]  acc_blk,
    input  logic [OFFW-1:0]  acc_off,
    input  logic [1:0]       acc_type,
    output logic             res_valid,
    output logic             res_grant,
    output logic [2:0]       res_cause
);
    op_e        op;
    blk_t       cinfo, ainfo;
    logic       c_hit, c_full, a_hit;
    logic [2:0] a_rights;
    logic       err, ok;

    assign op        = op_e'(cmd_op);
    assign acc_ready = !cmd_valid;
    assign ok        = cmd_valid && !err;

    always_comb begin
        unique case (op)
            OP_CREATE:  err = cinfo.ex || (cmd_lg < LOGW'(MINLOG)) || (cmd_lg > LOGW'(MAXLOG));
            OP_ENABLE,
            OP_DISABLE,
            OP_QUERY:   err = !cinfo.ex;
            OP_ATTACH:  err = !cinfo.ex || c_hit || c_full;
            OP_DETACH:  err = !c_hit;
            OP_FREE:    err = !cinfo.ex || (cinfo.refc != '0);
            default:    err = 1'b1;
        endcase
    end

    vbp_blk_table u_tbl (
        .clk       (clk),
        .rst       (rst),
        .wr_blk    (cmd_blk),
        .do_create (ok && op == OP_CREATE),
        .do_enable (ok && op == OP_ENABLE),
        .do_disable(ok && op == OP_DISABLE),
        .do_inc    (ok && op == OP_ATTACH),
        .do_dec    (ok && op == OP_DETACH),
        .do_free   (ok && op == OP_FREE),
        .new_lg    (cmd_lg),
        .new_prop  (cmd_prop),
        .ra_blk    (cmd_blk),
        .rb_blk    (acc_blk),
        .ra        (cinfo),
        .rb        (ainfo)
    );

    vbp_attach_list u_att (
        .clk      (clk),
        .rst      (rst),
        .c_proc   (cmd_proc),
        .c_blk    (cmd_blk),
        .c_rights (cmd_perm),
        .do_attach(ok && op == OP_ATTACH),
        .do_detach(ok && op == OP_DETACH),
        .c_hit    (c_hit),
        .c_full   (c_full),
        .a_proc   (acc_proc),
        .a_blk    (acc_blk),
        .a_hit    (a_hit),
        .a_rights (a_rights)
    );

    vbp_lookup u_lk (
        .clk      (clk),
        .rst      (rst),
        .fire     (acc_valid && acc_ready),
        .info     (ainfo),
        .hit      (a_hit),
        .rights   (a_rights),
        .kind     (acc_type),
        .off      (acc_off),
        .res_valid(res_valid),
        .res_grant(res_grant),
        .res_cause(res_cause)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_rsp_valid <= 1'b0;
            cmd_rsp_err   <= 1'b0;
            rsp_en        <= 1'b0;
            rsp_lg        <= '0;
            rsp_prop      <= '0;
            rsp_refcnt    <= '0;
        end else begin
            cmd_rsp_valid <= cmd_valid;
            cmd_rsp_err   <= cmd_valid && err;
            rsp_en        <= cinfo.en;
            rsp_lg        <= cinfo.lg;
            rsp_prop      <= cinfo.prop;
            rsp_refcnt    <= cinfo.refc;
        end
    end
endmodule

// File: rtl/vbp_guard_chk.sv
module vbp_guard_chk
    import vbp_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic            cmd_rsp_valid,
    input logic [REFW-1:0] rsp_refcnt,
    input logic            acc_valid,
    input logic            acc_ready,
    input logic            res_valid,
    input logic            res_grant,
    input logic [2:0]      res_cause
);
    // R9
    acc_result_due_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_ready) |=> res_valid);

    // R9
    no_stray_result_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_ready) |=> !res_valid);

    // R8
    grant_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_grant) |-> (res_cause == 3'd0));

    // R8
    fault_coded_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_grant) |-> (res_cause >= 3'd1 && res_cause <= 3'd4));

    // R6
    cmd_answer_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> cmd_rsp_valid);

    // R3
    refcnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_rsp_valid |-> (rsp_refcnt <= REFW'(NPROC)));
endmodule

bind vblk_guard vbp_guard_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_rsp_valid(cmd_rsp_valid),
    .rsp_refcnt   (rsp_refcnt),
    .acc_valid    (acc_valid),
    .acc_ready    (acc_ready),
    .res_valid    (res_valid),
    .res_grant    (res_grant),
    .res_cause    (res_cause)
);

// File: tb/sim_vblk_guard.sv
`timescale 1ns/1ps
module sim_vblk_guard;
    import vbp_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = '0;
    logic [BIDW-1:0]  cmd_blk = '0;
    logic [PIDW-1:0]  cmd_proc = '0;
    logic [2:0]       cmd_perm = '0;
    logic [LOGW-1:0]  cmd_lg = '0;
    logic [PROPW-1:0] cmd_prop = '0;
    logic             cmd_rsp_valid, cmd_rsp_err, rsp_en;
    logic [LOGW-1:0]  rsp_lg;
    logic [PROPW-1:0] rsp_prop;
    logic [REFW-1:0]  rsp_refcnt;
    logic             acc_valid = 1'b0;
    logic             acc_ready;
    logic [PIDW-1:0]  acc_proc = '0;
    logic [BIDW-1:0]  acc_blk = '0;
    logic [OFFW-1:0]  acc_off = '0;
    logic [1:0]       acc_type = '0;
    logic             res_valid, res_grant;
    logic [2:0]       res_cause;

    always #2 clk = ~clk;

    vblk_guard u0 (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    bit         m_ex [16];
    bit         m_en [16];
    int         m_lg [16];
    logic [7:0] m_prop [16];
    int         m_ref [16];
    bit         m_att [8][16];
    logic [2:0] m_rt [8][16];
    int         m_cnt [8];

    task automatic chk(input bit good, input string req, input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string op_req(input int op);
        case (op)
            0: return "R1";
            1, 2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            default: return "R2";
        endcase
    endfunction

    function automatic bit exp_err(input int op, input int b, input int p, input int lg);
        case (op)
            0: return m_ex[b] || lg < 12 || lg > 47;
            1, 2, 6: return !m_ex[b];
            3: return !m_ex[b] || m_att[p][b] || m_cnt[p] == 8;
            4: return !m_att[p][b];
            5: return !m_ex[b] || m_ref[b] != 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_cause(input int p, input int b, input int t, input longint off);
        if (!(m_ex[b] && m_en[b])) return 1;
        if (!m_att[p][b]) return 2;
        if (t == 3 || !m_rt[p][b][t]) return 3;
        if ((off >> m_lg[b]) != 0) return 4;
        return 0;
    endfunction

    task automatic cmd(input int op, input int b, input int p, input logic [2:0] rt,
                       input int lg, input logic [7:0] prop);
        bit e;
        string rq;
        e  = exp_err(op, b, p, lg);
        rq = op_req(op);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_blk = 4'(b); cmd_proc = 3'(p);
        cmd_perm = rt; cmd_lg = 6'(lg); cmd_prop = prop;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_rsp_valid == 1'b1, "R6 response strobe", cmd_rsp_valid, 1);
        chk(cmd_rsp_err == e, rq, cmd_rsp_err, e);
        if (op == 6 && !e) begin
            chk(rsp_lg == 6'(m_lg[b]), "R6 size", rsp_lg, m_lg[b]);
            chk(rsp_prop == m_prop[b], "R6 prop", rsp_prop, m_prop[b]);
            chk(rsp_en == m_en[b], "R6 enable", rsp_en, m_en[b]);
            chk(rsp_refcnt == 4'(m_ref[b]), "R6 refcnt", rsp_refcnt, m_ref[b]);
        end
        if (!e) begin
            case (op)
                0: begin m_ex[b] = 1; m_en[b] = 0; m_lg[b] = lg; m_prop[b] = prop; m_ref[b] = 0; end
                1: m_en[b] = 1;
                2: m_en[b] = 0;
                3: begin m_att[p][b] = 1; m_rt[p][b] = rt; m_ref[b]++; m_cnt[p]++; end
                4: begin m_att[p][b] = 0; m_ref[b]--; m_cnt[p]--; end
                5: begin m_ex[b] = 0; m_en[b] = 0; end
                default: ;
            endcase
        end
    endtask

    task automatic acc(input int p, input int b, input int t, input longint off, input string rq);
        int c;
        c = exp_cause(p, b, t, off);
        acc_valid = 1'b1; acc_proc = 3'(p); acc_blk = 4'(b); acc_type = 2'(t);
        acc_off = OFFW'(off);
        #1;
        chk(acc_ready == 1'b1, "R9 ready without command", acc_ready, 1);
        @(negedge clk);
        acc_valid = 1'b0;
        chk(res_valid == 1'b1, "R9 result strobe", res_valid, 1);
        chk(res_grant == (c == 0), rq, res_grant, c == 0);
        chk(res_cause == 3'(c), "R8 cause", res_cause, c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            m_ex[i] = 0; m_en[i] = 0; m_lg[i] = 0; m_prop[i] = 0; m_ref[i] = 0;
        end
        for (int p = 0; p < 8; p++) begin
            m_cnt[p] = 0;
            for (int i = 0; i < 16; i++) begin m_att[p][i] = 0; m_rt[p][i] = 0; end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(res_valid == 0 && cmd_rsp_valid == 0, "R9 reset outputs", res_valid, 0);
        chk(acc_ready == 1, "R9 reset ready", acc_ready, 1);

        // R1 create and size bounds
        cmd(0, 0, 0, 0, 12, 8'hA5);
        cmd(6, 0, 0, 0, 0, 0);
        cmd(0, 0, 0, 0, 20, 8'h11);
        cmd(0, 1, 0, 0, 11, 0);
        cmd(0, 1, 0, 0, 48, 0);
        // R2 command on absent block, reserved op
        cmd(1, 9, 0, 0, 0, 0);
        cmd(7, 0, 0, 0, 0, 0);
        // R8 priority: disabled wins over unattached
        acc(0, 0, 0, 0, "R8 disabled first");
        cmd(1, 0, 0, 0, 0, 0);
        acc(0, 0, 0, 0, "R8 unattached");
        // R3 attach, duplicate rejected
        cmd(3, 0, 0, 3'b001, 0, 0);
        cmd(3, 0, 0, 3'b111, 0, 0);
        cmd(6, 0, 0, 0, 0, 0);
        acc(0, 0, 1, 0, "R7 write without right");
        acc(0, 0, 0, 4095, "R7 last byte");
        acc(0, 0, 0, 4096, "R7 past end");
        acc(0, 0, 3, 0, "R7 kind 3");
        // R3 different rights per process
        cmd(3, 0, 1, 3'b010, 0, 0);
        acc(1, 0, 1, 100, "R3 write right of process 1");
        acc(1, 0, 0, 100, "R3 no read for process 1");
        // R5 free blocked, R4 detach
        cmd(5, 0, 0, 0, 0, 0);
        cmd(4, 0, 0, 0, 0, 0);
        cmd(4, 0, 0, 0, 0, 0);
        cmd(6, 0, 0, 0, 0, 0);
        cmd(4, 0, 1, 0, 0, 0);
        cmd(5, 0, 0, 0, 0, 0);
        cmd(6, 0, 0, 0, 0, 0);
        acc(1, 0, 1, 0, "R5 freed block");
        // R3 capacity of 8 per process
        for (int b = 2; b <= 10; b++) begin
            cmd(0, b, 0, 0, 47, 8'(b));
            cmd(1, b, 0, 0, 0, 0);
            cmd(3, b, 2, 3'b100, 0, 0);
        end
        cmd(6, 10, 0, 0, 0, 0);
        acc(2, 9, 2, 64'h7FFF_FFFF_FFFF, "R7 top offset of largest size");
        acc(2, 10, 2, 0, "R3 overflow attach left no entry");
        // R10 property vector ignored
        cmd(0, 11, 0, 0, 16, 8'hFF);
        cmd(0, 12, 0, 0, 16, 8'h00);
        cmd(1, 11, 0, 0, 0, 0);
        cmd(1, 12, 0, 0, 0, 0);
        cmd(3, 11, 5, 3'b011, 0, 0);
        cmd(3, 12, 5, 3'b011, 0, 0);
        acc(5, 11, 1, 65535, "R10 prop FF");
        acc(5, 12, 1, 65535, "R10 prop 00");
        // R9 command wins over a simultaneous access
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_blk = 4'd11;
        acc_valid = 1'b1; acc_proc = 3'd5; acc_blk = 4'd11; acc_type = 2'd0; acc_off = '0;
        #1;
        chk(acc_ready == 1'b0, "R9 ready low under command", acc_ready, 0);
        @(negedge clk);
        cmd_valid = 1'b0; acc_valid = 1'b0;
        chk(res_valid == 1'b0, "R9 no result for refused access", res_valid, 0);
        chk(cmd_rsp_valid == 1'b1, "R9 command served", cmd_rsp_valid, 1);

        // random mix
        for (int it = 0; it < 3000; it++) begin
            int b, p, t, s;
            longint off;
            b = $urandom % 16; p = $urandom % 8;
            if ($urandom % 2) begin
                int op, lg;
                op = $urandom % 8;
                lg = 10 + ($urandom % 40);
                cmd(op, b, p, 3'($urandom), lg, 8'($urandom));
            end else begin
                t = $urandom % 4;
                s = m_ex[b] ? m_lg[b] : 20;
                case ($urandom % 4)
                    0: off = (longint'(1) << s) - 1;
                    1: off = longint'(1) << s;
                    2: off = {$urandom, $urandom} & 64'h7FFF_FFFF_FFFF;
                    default: off = {$urandom, $urandom} & ((longint'(1) << s) - 1);
                endcase
                if (s >= 47) off = off & 64'h7FFF_FFFF_FFFF;
                acc(p, b, t, off, "R7 random access");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule